// File: doc/BRIEF.md
# CORDIC Double-Sideband Test-Tone Modulator

This block synthesizes a double-sideband, suppressed-carrier test signal in fixed point and delivers it as an unsigned 8-bit DAC code. A phase counter supplies two angles: a slow message angle and a carrier angle locked to exactly twenty times the message rate. A single iterative CORDIC rotator is shared between two passes per sample. The first pass turns a constant magnitude of 100 through the message angle and keeps the X result as the message sample. The second pass turns that sample through the carrier angle. The X and Y results are summed, clipped to the signed 8-bit range, and mapped to a DAC code.

Each rising sample strobe starts one sample when the block is enabled and idle. The result appears with a one-cycle valid pulse after a fixed latency. The controller has four states. IDLE waits for a strobe (the IDLE-to-MSG transition). MSG runs the message pass and moves to CARRIER when the rotator reports done. CARRIER runs the carrier pass and moves to OUT when the rotator reports done. OUT publishes the code, advances the phase and returns to IDLE. A low enable sends every state straight back to IDLE. The only way to restart both phases from zero is to drop enable or apply reset.

Top module: `dsb_modulator`

## Requirements
- R1: After synchronous reset `code_o` is 0x80 (128), `valid_o` is 0, and the next sample uses phase counter value 0.
- R2: Angles are 32-bit fractions of a full turn. The message angle is the phase counter shifted left by 16. The counter starts at 0 and gains 0x800 per completed sample, so sample n has message angle n/32 of a turn and the sequence repeats every 32 samples.
- R3: The carrier angle is (20 × counter) shifted left by 16, truncated to 32 bits. Sample n therefore has carrier angle (20·n mod 32)/32 of a turn.
- R4: The message sample equals 100·cos(message angle), rounded, within ±1.
- R5: The output value s equals m·cos(carrier) + m·sin(carrier), where m is the message sample. It matches within ±3 of the real-valued result when no clipping occurs.
- R6: Before mapping, s is clipped to the range −128..127.
- R7: `code_o` = (128 − s) mod 256. So s = 100 gives 28, s = 0 gives 128, s = −128 gives 0, and s = 127 gives 1.
- R8: `valid_o` is high for exactly one cycle per accepted strobe. `code_o` changes only in a cycle where `valid_o` is high. A strobe that arrives outside IDLE is ignored.
- R9: The phase counter advances only when a sample completes (OUT). Ignored strobes and idle gaps of any length leave the sample index unchanged.
- R10: While `en` is low, no strobe is accepted, `valid_o` stays low, any sample in progress is abandoned, and the phase counter is held at 0. The first sample after re-enabling uses counter value 0.
- R11: `valid_o` rises exactly 2·ITER+3 clock edges after the edge that accepts the strobe (35 edges for 16 iterations).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low clears phase and aborts the sample |
| strobe_i | input | 1 | Sample request, accepted only in IDLE |
| code_o | output | 8 | Unsigned DAC code, (128 − s) mod 256 |
| valid_o | output | 1 | One-cycle pulse when a new code is presented |

## Verification
The bench walks forty consecutive samples, which covers a full message cycle plus its wrap. It varies idle gaps and injects stray strobes during the MSG, CARRIER and OUT states. A design that accepted a stray strobe would skip a phase step, and every later value would then be wrong. Sample 1 lands the carrier at 225 degrees, where the unclipped sum is about −139. A design without clipping would wrap this to a code near 10 instead of 0, and samples 8 and 16 check the zero-crossing and negative-peak codes of the message. Dropping enable in mid-sample, and resetting in mid-sample, must both suppress the pending valid and restart at phase zero. A design that only paused the phase counter would resume at a later sample. A held-high strobe must give exactly one sample per 36 cycles.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    localparam int ANG_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MSG     = 2'd1,
        ST_CARRIER = 2'd2,
        ST_OUT     = 2'd3
    } dsb_state_e;

    // arctan(2^-i) expressed as a fraction of a full turn, scaled by 2^32
    function automatic logic [ANG_W-1:0] atan_turn(input int idx);
        logic [ANG_W-1:0] r;
        case (idx)
            0:       r = 32'h2000_0000;
            1:       r = 32'h12E4_051E;
            2:       r = 32'h09FB_385B;
            3:       r = 32'h0511_11D4;
            4:       r = 32'h028B_0D43;
            5:       r = 32'h0145_D7E1;
            6:       r = 32'h00A2_F61E;
            7:       r = 32'h0051_7C55;
            8:       r = 32'h0028_BE53;
            9:       r = 32'h0014_5F2F;
            10:      r = 32'h000A_2F98;
            11:      r = 32'h0005_17CC;
            12:      r = 32'h0002_8BE6;
            13:      r = 32'h0001_45F3;
            14:      r = 32'h0000_A2FA;
            15:      r = 32'h0000_517D;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsb_phase_gen.sv
module dsb_phase_gen
    import dsb_pkg::*;
#(
    parameter logic [ANG_W-1:0] STEP  = 32'h0000_0800,
    parameter int               MULT  = 20,
    parameter int               SHIFT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [ANG_W-1:0] cnt_o,
    output logic [ANG_W-1:0] msg_ang,
    output logic [ANG_W-1:0] car_ang
);

    localparam logic [ANG_W-1:0] MULT_V = ANG_W'(MULT);

    logic [ANG_W-1:0] cnt_q;
    logic [ANG_W-1:0] car_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + STEP;
        end
    end

    always_comb begin
        car_cnt = cnt_q * MULT_V;
        msg_ang = cnt_q << SHIFT;
        car_ang = car_cnt << SHIFT;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/dsb_cordic.sv
module dsb_cordic
    import dsb_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int FRAC = 8,
    parameter int ITER = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   start,
    input  logic signed [IN_W-1:0] din,
    input  logic [ANG_W-1:0]       ang,
    output logic                   busy,
    output logic                   done,
    output logic signed [IN_W-1:0] x_res,
    output logic signed [IN_W-1:0] y_res
);

    localparam int DW    = IN_W + FRAC + 2;
    localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
    localparam int PW    = IN_W + 18;
    localparam int KSH   = 16;
    // inverse CORDIC gain, 0.60725 in Q16
    localparam logic signed [PW-1:0] KQ   = PW'(39797);
    localparam logic signed [DW-1:0] HALF = DW'(1) <<< (FRAC - 1);
    localparam logic [CNT_W-1:0]     LAST = CNT_W'(ITER - 1);

    logic signed [DW-1:0]    x_q, y_q;
    logic signed [ANG_W-1:0] z_q;
    logic [CNT_W-1:0]        it_q;
    logic                    busy_q, done_q;

    logic signed [DW-1:0]    x_pre, x_ld, y_ld;
    logic signed [ANG_W-1:0] z_ld;
    logic                    fold;

    logic signed [DW-1:0]    xs, ys, x_n, y_n;
    logic signed [ANG_W-1:0] z_n, step_ang;
    logic                    ccw;

    // load: gain pre-compensation and quadrant fold
    always_comb begin
        x_pre = DW'(($signed({{18{din[IN_W-1]}}, din}) * KQ) >>> (KSH - FRAC));
        fold  = (ang[ANG_W-1:ANG_W-2] == 2'b01) || (ang[ANG_W-1:ANG_W-2] == 2'b10);
        x_ld  = fold ? -x_pre : x_pre;
        y_ld  = '0;
        z_ld  = fold ? $signed(ang ^ {1'b1, {(ANG_W-1){1'b0}}}) : $signed(ang);
    end

    // one micro-rotation
    always_comb begin
        ccw      = ~z_q[ANG_W-1];
        step_ang = $signed(atan_turn(int'(it_q)));
        xs       = x_q >>> it_q;
        ys       = y_q >>> it_q;
        x_n      = ccw ? (x_q - ys) : (x_q + ys);
        y_n      = ccw ? (y_q + xs) : (y_q - xs);
        z_n      = ccw ? (z_q - step_ang) : (z_q + step_ang);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            it_q   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            x_q    <= x_ld;
            y_q    <= y_ld;
            z_q    <= z_ld;
            it_q   <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            x_q    <= x_n;
            y_q    <= y_n;
            z_q    <= z_n;
            it_q   <= it_q + 1'b1;
            busy_q <= (it_q != LAST);
            done_q <= (it_q == LAST);
        end else begin
            done_q <= 1'b0;
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign x_res = IN_W'((x_q + HALF) >>> FRAC);
    assign y_res = IN_W'((y_q + HALF) >>> FRAC);

endmodule

// File: rtl/dsb_dac_map.sv
module dsb_dac_map #(
    parameter int SUM_W    = 17,
    parameter int CODE_W   = 8,
    parameter bit SATURATE = 1'b1
) (
    input  logic signed [SUM_W-1:0] sum,
    output logic [CODE_W-1:0]       code
);

    localparam logic signed [SUM_W-1:0] HI  = SUM_W'((1 << (CODE_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO  = -SUM_W'(1 << (CODE_W - 1));
    localparam logic signed [SUM_W-1:0] MID = SUM_W'(1 << (CODE_W - 1));

    logic signed [SUM_W-1:0] lim;
    logic signed [SUM_W-1:0] diff;

    generate
        if (SATURATE) begin : g_clip
            always_comb begin
                if (sum > HI)      lim = HI;
                else if (sum < LO) lim = LO;
                else               lim = sum;
            end
        end else begin : g_wrap
            always_comb lim = sum;
        end
    endgenerate

    always_comb begin
        diff = MID - lim;
        code = diff[CODE_W-1:0];
    end

endmodule

// File: rtl/dsb_modulator.sv
module dsb_modulator
    import dsb_pkg::*;
#(
    parameter int               IN_W     = 16,
    parameter int               FRAC     = 8,
    parameter int               ITER     = 16,
    parameter int               MAG      = 100,
    parameter int               CAR_MULT = 20,
    parameter logic [ANG_W-1:0] STEP     = 32'h0000_0800,
    parameter int               SHIFT    = 16,
    parameter int               CODE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              strobe_i,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o
);

    localparam int                SUM_W = IN_W + 1;
    localparam logic [CODE_W-1:0] MIDC  = CODE_W'(1 << (CODE_W - 1));

    dsb_state_e state_q, state_d;

    logic                    accept;
    logic                    cor_start, cor_busy, cor_done;
    logic signed [IN_W-1:0]  cor_din, cx, cy;
    logic [ANG_W-1:0]        cor_ang;
    logic [ANG_W-1:0]        phase_cnt, msg_ang, car_ang;
    logic                    phase_adv;
    logic signed [SUM_W-1:0] acc_q;
    logic [CODE_W-1:0]       map_code, code_q;
    logic                    valid_q;

    assign accept    = en && strobe_i && (state_q == ST_IDLE);
    assign phase_adv = en && (state_q == ST_OUT);
    assign cor_start = accept || (en && (state_q == ST_MSG) && cor_done);
    assign cor_din   = (state_q == ST_MSG) ? cx : IN_W'(MAG);
    assign cor_ang   = (state_q == ST_MSG) ? car_ang : msg_ang;

    dsb_phase_gen #(
        .STEP  (STEP),
        .MULT  (CAR_MULT),
        .SHIFT (SHIFT)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .clr     (!en),
        .adv     (phase_adv),
        .cnt_o   (phase_cnt),
        .msg_ang (msg_ang),
        .car_ang (car_ang)
    );

    dsb_cordic #(
        .IN_W (IN_W),
        .FRAC (FRAC),
        .ITER (ITER)
    ) u_cordic (
        .clk   (clk),
        .rst   (rst),
        .clr   (!en),
        .start (cor_start),
        .din   (cor_din),
        .ang   (cor_ang),
        .busy  (cor_busy),
        .done  (cor_done),
        .x_res (cx),
        .y_res (cy)
    );

    dsb_dac_map #(
        .SUM_W    (SUM_W),
        .CODE_W   (CODE_W),
        .SATURATE (1'b1)
    ) u_map (
        .sum  (acc_q),
        .code (map_code)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (strobe_i) state_d = ST_MSG;
                ST_MSG:     if (cor_done) state_d = ST_CARRIER;
                ST_CARRIER: if (cor_done) state_d = ST_OUT;
                ST_OUT:     state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            code_q  <= MIDC;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (accept) begin
                acc_q <= '0;
            end else if (en && (state_q == ST_CARRIER) && cor_done) begin
                acc_q <= acc_q + SUM_W'(cx) + SUM_W'(cy);
            end
            if (en && (state_q == ST_OUT)) begin
                code_q  <= map_code;
                valid_q <= 1'b1;
            end
        end
    end

    assign code_o  = code_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/dsb_modulator_chk.sv
module dsb_modulator_chk
    import dsb_pkg::*;
#(
    parameter int               ITER   = 16,
    parameter logic [ANG_W-1:0] STEP   = 32'h0000_0800,
    parameter int               CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              strobe_i,
    input logic              valid_o,
    input logic [CODE_W-1:0] code_o,
    input dsb_state_e        state,
    input logic [ANG_W-1:0]  phase,
    input logic              busy
);

    localparam logic [15:0] LAT = 16'(2 * ITER + 4);

    logic [15:0] lat;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            lat <= '0;
        end else if (state == ST_IDLE && strobe_i) begin
            lat <= 16'd1;
        end else if (lat != 16'd0 && lat != 16'hFFFF) begin
            lat <= lat + 16'd1;
        end
    end

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_code_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(code_o));

    assert_strobe_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (en && (state == ST_CARRIER || state == ST_OUT)) |=> state != ST_MSG);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !busy);

    assert_phase_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (en && state != ST_OUT) |=> $stable(phase));

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_OUT) |=> phase == $past(phase) + STEP);

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (phase == '0 && state == ST_IDLE && !valid_o));

    assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> lat == LAT);

endmodule

bind dsb_modulator dsb_modulator_chk #(
    .ITER   (ITER),
    .STEP   (STEP),
    .CODE_W (CODE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .strobe_i (strobe_i),
    .valid_o  (valid_o),
    .code_o   (code_o),
    .state    (state_q),
    .phase    (phase_cnt),
    .busy     (cor_busy)
);

// File: tb/sim_dsb_modulator.sv
`timescale 1ns/1ps
module sim_dsb_modulator;

    localparam real PI      = 3.14159265358979;
    localparam int  LAT_NEG = 36;   // 35 edges after acceptance, seen at next negedge
    localparam int  NSAMP   = 40;
    localparam int  GAP_TBL  [8] = '{0, 3, 1, 7, 2, 0, 5, 1};
    localparam int  BUSY_TBL [8] = '{0, 5, 0, 20, 0, 35, 0, 2};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       strobe_i = 1'b0;
    logic [7:0] code_o;
    logic       valid_o;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dsb_modulator u0 (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .strobe_i (strobe_i),
        .code_o   (code_o),
        .valid_o  (valid_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input real v);
        return $rtoi($floor(v + 0.5));
    endfunction

    function automatic int msg_val(input int n);
        return rnd(100.0 * $cos(2.0 * PI * (n % 32) / 32.0));
    endfunction

    function automatic real sum_real(input int n);
        real c;
        c = 2.0 * PI * ((20 * n) % 32) / 32.0;
        return msg_val(n) * ($cos(c) + $sin(c));
    endfunction

    function automatic int clip(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int decode(input logic [7:0] c);
        return (c == 8'd0) ? -128 : 128 - int'(c);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // pulses strobe, optionally a stray one at negedge index 'stray'; returns latency
    task automatic run_sample(input int stray, output int lat, output logic [7:0] code);
        @(negedge clk) strobe_i = 1'b1;
        lat = 0;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            strobe_i = (stray != 0 && k == stray);
            if (valid_o) begin
                lat = k;
                break;
            end
        end
        strobe_i = 1'b0;
        code = code_o;
    endtask

    task automatic count_valid(input int ncyc, output int cnt);
        cnt = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (valid_o) cnt++;
        end
    endtask

    initial begin
        int         lat;
        int         cnt;
        int         exp_s;
        int         got_s;
        logic [7:0] code;

        repeat (3) @(negedge clk);
        check(code_o == 8'h80, "R1", "reset code", int'(code_o), 128);
        check(valid_o == 1'b0, "R1", "reset valid", int'(valid_o), 0);
        rst = 1'b0;
        en  = 1'b1;

        // table-driven walk over 40 consecutive samples
        for (int n = 0; n < NSAMP; n++) begin
            repeat (GAP_TBL[n % 8]) @(negedge clk);
            run_sample(BUSY_TBL[n % 8], lat, code);
            check(lat == LAT_NEG, "R11", "latency", lat, LAT_NEG);
            got_s = decode(code);
            exp_s = clip(rnd(sum_real(n)));
            if (n % 8 == 0) begin
                // carrier at a whole turn: output equals the message sample
                check(iabs(got_s - clip(msg_val(n))) <= 1, "R4", $sformatf("message n=%0d", n),
                      got_s, clip(msg_val(n)));
            end else if (sum_real(n) > 127.5 || sum_real(n) < -128.5) begin
                check(iabs(got_s - exp_s) <= 1, "R6", $sformatf("clip n=%0d", n), got_s, exp_s);
            end else begin
                check(iabs(got_s - exp_s) <= 3, "R5", $sformatf("sum n=%0d R3 R9", n), got_s, exp_s);
            end
            if (BUSY_TBL[n % 8] != 0) begin
                count_valid(45, cnt);
                check(cnt == 0, "R8", $sformatf("stray strobe n=%0d", n), cnt, 0);
            end
        end

        // exact code mapping: restart phase, sample 0 gives s = 100
        @(negedge clk) en = 1'b0;
        @(negedge clk) en = 1'b1;
        run_sample(0, lat, code);
        check(code == 8'd28, "R7", "code for s=100", int'(code), 28);
        run_sample(0, lat, code);
        check(code == 8'd0, "R7", "code for s=-128 (R6 clip)", int'(code), 0);

        // held strobe: one sample per 36 cycles
        @(negedge clk) strobe_i = 1'b1;
        count_valid(108, cnt);
        strobe_i = 1'b0;
        check(cnt == 3, "R8", "held strobe pulses", cnt, 3);

        // disable in mid-sample
        @(negedge clk) strobe_i = 1'b1;
        @(negedge clk) strobe_i = 1'b0;
        repeat (10) @(negedge clk);
        en = 1'b0;
        count_valid(45, cnt);
        check(cnt == 0, "R10", "abort on disable", cnt, 0);
        strobe_i = 1'b1;
        count_valid(45, cnt);
        strobe_i = 1'b0;
        check(cnt == 0, "R10", "strobe while disabled", cnt, 0);
        en = 1'b1;
        run_sample(0, lat, code);
        check(code == 8'd28, "R10", "phase restart", int'(code), 28);
        run_sample(0, lat, code);
        check(code == 8'd0, "R10", "second sample after restart", int'(code), 0);

        // reset in mid-sample
        @(negedge clk) strobe_i = 1'b1;
        @(negedge clk) strobe_i = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(code_o == 8'h80, "R1", "code after mid reset", int'(code_o), 128);
        check(valid_o == 1'b0, "R1", "valid after mid reset", int'(valid_o), 0);
        rst = 1'b0;
        count_valid(45, cnt);
        check(cnt == 0, "R1", "no valid after reset", cnt, 0);
        run_sample(0, lat, code);
        check(code == 8'd28, "R1", "phase zero after reset", int'(code), 28);
        check(lat == LAT_NEG, "R11", "latency after reset", lat, LAT_NEG);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule